// File: doc/BRIEF.md
# Bidirectional Port with Synchronized Pin Readback

This block is an eight-pin general-purpose I/O port for a small register bus. Software sets a direction byte and a drive byte; from those two bytes and a chip-wide pull-up kill input, the block derives three signals for each pin: output-enable, output value and pull-up enable. These go to a pad, which is modelled outside the block. The pad's resolved level returns on `pad_in`. It passes through a two-stage synchronizer, and the result can be read back as the pin byte in any direction mode.

The bus is a plain synchronous port with an address, a write strobe and write data. Read data is registered and appears one clock after its address is presented. The pin byte is read-only. Writes to it and to the unused fourth offset are discarded. The direction byte and the drive byte come out of reset as zero, so every pin starts as a floating input.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it, the direction byte and drive byte are 0, so `pad_oe`, `pad_out`, `pad_pu` and `bus_rdata` are all 0.
- R2: A write with `bus_addr` = 1 loads `bus_wdata` into the direction byte, and a write with `bus_addr` = 2 loads the drive byte. Writes to addresses 0 and 3 change neither byte.
- R3: For every pin, `pad_oe` equals its direction bit and `pad_out` equals its drive bit.
- R4: `pad_pu` of a pin is 1 only when its direction bit is 0, its drive bit is 1 and `pud_all` is 0. A pin in output mode never has its pull-up on.
- R5: Read data reflects the address sampled on the previous rising edge: address 1 gives the direction byte, 2 gives the drive byte, and 3 gives 0.
- R6: Address 0 returns the synchronized pin byte whatever the direction bits are. A pin in output mode therefore reads back the level it drives.
- R7: The pin byte after a rising edge holds the pad level present at the falling edge just before it. A pad change during the high phase is visible on `bus_rdata` (address 0 held) at the second rising edge after the change. A change during the low phase is visible at the third.
- R8: Because direction and drive are separate bytes, no pin's `pad_oe` and `pad_out` both change on the same clock. Every move between 00 and 11, or between 01 and 10, passes through an intermediate state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pud_all | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Resolved pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The bench builds the block with its default width of 8 pins and a 2-bit address. At this width, all four register offsets, including the unmapped one, can be reached in random traffic. The bench models a pad whose upper pins are driven externally and whose lower pins fall back to the pull-up. This lets the pull-up, the external drive and the output drive each feed the synchronizer. External level changes are placed in both clock phases, which exercises both the short and the long synchronizer delay.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // pull-up rule for one pin: input mode, drive bit high, not globally killed
  function automatic logic pin_pullup(input logic dir_b, input logic drv_b,
                                      input logic kill);
    return (~dir_b) & drv_b & (~kill);
  endfunction

  // read mux selection codes
  typedef enum logic [1:0] {
    SEL_PIN  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DRV  = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pin_val,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  drv_q,
  output logic [WIDTH-1:0]  rdata
);
  import gpio_pkg::*;

  localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DRV = ADDR_W'(2);

  logic    dir_wr, drv_wr;
  rd_sel_e sel;
  logic [WIDTH-1:0] rd_next;

  assign dir_wr = we && (addr == A_DIR);
  assign drv_wr = we && (addr == A_DRV);

  always_comb begin
    if (addr == A_PIN)      sel = SEL_PIN;
    else if (addr == A_DIR) sel = SEL_DIR;
    else if (addr == A_DRV) sel = SEL_DRV;
    else                    sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_PIN: rd_next = pin_val;
      SEL_DIR: rd_next = dir_q;
      SEL_DRV: rd_next = drv_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      drv_q <= '0;
      rdata <= '0;
    end else begin
      if (dir_wr) dir_q <= wdata;
      if (drv_wr) drv_q <= wdata;
      rdata <= rd_next;
    end
  end

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_DIR) |=> (dir_q == $past(wdata)));
  // R2
  drv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == A_DRV) |=> $stable(drv_q));
  // R5
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(3)) |=> (rdata == '0));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] drv_q,
  input  logic             pud_all,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] o,
  output logic [WIDTH-1:0] pu
);
  import gpio_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign oe[i] = dir_q[i];
    assign o[i]  = drv_q[i];
    assign pu[i] = pin_pullup(dir_q[i], drv_q[i], pud_all);
  end

  // R4
  pu_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pud_all |-> (pu == '0));
  // R4
  pu_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu & oe) == '0));
  // R8
  no_dual_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((oe ^ $past(oe)) & (o ^ $past(o))) == '0));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pin_q
);
  // negative-phase stage: holds the pad level from the falling edge
  // through the low phase, as the transparent-high latch would
  logic [WIDTH-1:0] neg_q;

  always_ff @(negedge clk) neg_q <= pad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= neg_q;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              pud_all,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu
);
  logic [WIDTH-1:0] dir_q, drv_q, pin_sync;

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pin_q(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .pin_val(pin_sync), .dir_q(dir_q), .drv_q(drv_q),
    .rdata(bus_rdata)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .drv_q(drv_q),
    .pud_all(pud_all), .oe(pad_oe), .o(pad_out), .pu(pad_pu)
  );

  // R6
  pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |=> (bus_rdata == $past(pin_sync)));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_we = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic pud_all = 1'b0;
  logic [W-1:0] pad, pad_oe, pad_out, pad_pu;
  logic [W-1:0] ext_val = '0, ext_en = '0;

  always #2 clk = ~clk;

  gpio_port #(.WIDTH(W), .ADDR_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pud_all(pud_all),
    .pad_in(pad), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  // pad model: own drive wins, then external drive, then pull-up, else low
  always_comb
    for (int i = 0; i < W; i++)
      pad[i] = pad_oe[i] ? pad_out[i] : (ext_en[i] ? ext_val[i] : pad_pu[i]);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [W-1:0] m_dir = '0, m_drv = '0, m_pin = '0, m_rd = '0;
  logic [W-1:0] fall_lvl = '0, prev_oe = '0, prev_o = '0;
  logic [1:0] last_addr = 2'd0;

  function automatic logic [W-1:0] exp_pu(input logic [W-1:0] d,
                                          input logic [W-1:0] v, input logic k);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      case ({d[i], v[i]})
        2'b01:   r[i] = (k == 1'b0);
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  always @(negedge clk) fall_lvl = pad;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = '0; m_drv = '0; m_pin = '0; m_rd = '0;
    end else begin
      last_addr = bus_addr;
      if (bus_addr == 2'd0)      m_rd = m_pin;
      else if (bus_addr == 2'd1) m_rd = m_dir;
      else if (bus_addr == 2'd2) m_rd = m_drv;
      else                       m_rd = '0;
      m_pin = fall_lvl;
      if (bus_we && bus_addr == 2'd1) m_dir = bus_wdata;
      if (bus_we && bus_addr == 2'd2) m_drv = bus_wdata;
    end
    #1;
    if (!rst_n) begin
      chk(pad_oe == '0, "R1", pad_oe, '0);
      chk(pad_pu == '0, "R1", pad_pu, '0);
      chk(bus_rdata == '0, "R1", bus_rdata, '0);
    end else begin
      if (last_addr == 2'd0)      chk(bus_rdata == m_rd, "R6", bus_rdata, m_rd);
      else if (last_addr == 2'd3) chk(bus_rdata == m_rd, "R5", bus_rdata, m_rd);
      else                        chk(bus_rdata == m_rd, "R2", bus_rdata, m_rd);
      chk(pad_oe == m_dir, "R3", pad_oe, m_dir);
      chk(pad_out == m_drv, "R3", pad_out, m_drv);
      chk(pad_pu == exp_pu(m_dir, m_drv, pud_all), "R4", pad_pu,
          exp_pu(m_dir, m_drv, pud_all));
      chk(((pad_oe ^ prev_oe) & (pad_out ^ prev_o)) == '0, "R8",
          (pad_oe ^ prev_oe) & (pad_out ^ prev_o), '0);
    end
    prev_oe = pad_oe;
    prev_o  = pad_out;
  end

  task automatic bus(input logic [1:0] a, input logic w, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = w; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // count rising edges until the pin-7 readback shows level v
  task automatic edges_until(input logic v, output int n);
    n = 0;
    while (n < 6) begin
      @(posedge clk); #1;
      n++;
      if (bus_rdata[7] == v) break;
    end
  endtask

  bit done = 1'b0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: first cycle after reset
    chk(pad_oe == '0 && pad_out == '0, "R1", pad_oe | pad_out, '0);

    // R2: writes to pin and unmapped offsets are discarded
    bus(2'd0, 1'b1, 8'hFF);
    bus(2'd3, 1'b1, 8'hFF);
    bus(2'd1, 1'b0, '0);
    @(posedge clk); #1;
    chk(bus_rdata == '0, "R2", bus_rdata, '0);

    // R5: one-cycle read latency after a write
    bus(2'd2, 1'b1, 8'h5A);
    @(negedge clk); bus_addr = 2'd2;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(bus_rdata == 8'h5A, "R5", bus_rdata, 8'h5A);

    // R4: pull-ups on 01 pins, then globally killed
    bus(2'd2, 1'b1, 8'h0F);
    chk(pad_pu == 8'h0F, "R4", pad_pu, 8'h0F);
    @(negedge clk); pud_all = 1'b1;
    @(posedge clk); #1;
    chk(pad_pu == '0, "R4", pad_pu, '0);
    @(negedge clk); pud_all = 1'b0;

    // R8: 00 -> 11 via 01 on pin 4 and pins 0..3 to 10 via 00
    bus(2'd2, 1'b1, 8'h1F);
    bus(2'd1, 1'b1, 8'h10);
    bus(2'd2, 1'b1, 8'h10);
    bus(2'd1, 1'b1, 8'h1F);

    // R6: output pins read back their driven level
    @(negedge clk); bus_addr = 2'd0;
    repeat (3) @(posedge clk); #1;
    chk(bus_rdata[4:0] == 5'b10000, "R6", {3'b0, bus_rdata[4:0]}, 8'h10);

    // R7: externally driven pin 7, change in high phase then low phase
    ext_en = 8'hE0; ext_val = '0;
    repeat (3) @(posedge clk);
    #1 ext_val[7] = 1'b1;
    edges_until(1'b1, n);
    chk(n == 2, "R7", 8'(n), 8'd2);
    @(negedge clk); #0.5 ext_val[7] = 1'b0;
    edges_until(1'b0, n);
    chk(n == 3, "R7", 8'(n), 8'd3);

    // mixed traffic against the reference model
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      bus_addr = 2'($urandom_range(0, 3));
      bus_we = ($urandom_range(0, 2) == 0);
      bus_wdata = 8'($urandom);
      if ((k % 16) == 0) pud_all = ~pud_all;
      if ((k % 3) == 0) #0.5 ext_val = 8'($urandom);
      else if ((k % 3) == 1) begin @(posedge clk); #0.5 ext_val = 8'($urandom); end
    end
    @(negedge clk); bus_we = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule